// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block takes one binary32 operand per valid strobe and rounds it to an integral value that is still in binary32 format. The direction of rounding comes either from the operation code or, for the two dynamic operations, from a 2-bit mode supplied beside the operand. That mode would normally be driven from the floating-point control register. The result and two exception flags (inexact, invalid) appear a fixed number of clock cycles later. That number is set by the `LATENCY` parameter, and a new operation may be issued every cycle.

The rounding datapath works on the combined exponent-and-mantissa field as one unsigned magnitude. Because of this, a round-up that carries out of the mantissa moves into the exponent by itself. Values whose magnitude is below one are handled on their own path. NaNs, infinities, zeros and operands that are already integral leave the unit without being changed, except that a signalling NaN is quieted.

Top module: `fpri_top`

## Requirements
- R1: After reset `out_valid` is 0. Each cycle with `in_valid` high gives exactly one cycle of `out_valid` high, `LATENCY` clock cycles later. Back-to-back operations give back-to-back results, in the order they were issued.
- R2: Operation code 0 rounds to the nearest integer, and an exact half goes to the even integer (2.5 gives 2.0, 1.5 gives 2.0).
- R3: Operation code 1 rounds to the nearest integer, and an exact half goes away from zero (2.5 gives 3.0, -0.5 gives -1.0).
- R4: Operation code 2 rounds toward +infinity. Code 3 rounds toward -infinity. Code 4 rounds toward zero.
- R5: Operation codes 5 and 7 take their direction from `in_dyn_mode`: 00 is nearest-even, 01 is toward +infinity, 10 is toward -infinity, 11 is toward zero. These codes never raise inexact.
- R6: Operation code 6 uses the same `in_dyn_mode` decoding as R5. It raises `out_inexact` whenever the result differs from the operand.
- R7: Operation codes 0 to 5 and 7 never raise `out_inexact`. Inexact and invalid are never raised together.
- R8: The following operands pass through unchanged and raise no flag under every operation code: operands with an unbiased exponent of 23 or more, infinities, and zeros of either sign.
- R9: The result keeps the sign of the operand. A small negative value that rounds up gives -0 (0x80000000).
- R10: A signalling NaN (exponent all ones, mantissa bit 22 clear, mantissa non-zero) returns the same NaN with bit 22 set and raises `out_invalid`. A quiet NaN passes through with no flag.
- R11: A non-zero operand with magnitude below 1.0 gives a result of ±0 or ±1.0 (0x3F800000 with its sign bit), depending on the direction and the sign.
- R12: A round-up that overflows the mantissa increments the exponent (8388607.5 rounded toward +infinity gives 0x4B000000).
- R13: `out_inexact` and `out_invalid` are 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 3 | Operation code (0 nearest-even, 1 ties-away, 2 up, 3 down, 4 zero, 5/7 dynamic, 6 dynamic with inexact) |
| in_dyn_mode | input | 2 | Dynamic rounding direction for codes 5 to 7 |
| in_a | input | 32 | binary32 operand |
| out_valid | output | 1 | Result strobe, `LATENCY` cycles after `in_valid` |
| out_res | output | 32 | Integral binary32 result |
| out_inexact | output | 1 | Inexact flag (code 6 only) |
| out_invalid | output | 1 | Invalid flag (signalling NaN operand) |

## Verification
A pipeline stage that loses or gains a valid bit shows up at once as a strobe in the wrong cycle, a missing strobe, or an extra one. Results arriving out of order also show up at once when operations are issued back to back. A wrong direction decode or a wrong half-way comparison gives a result one unit off, on the first operand that sits on or near a tie. Each direction is fed such operands. A stale sign, a lost mantissa carry, or a flag left over from an earlier operation shows in the very result strobe that carries it. These are checked against values worked out by hand for each corner.

// File: rtl/fpri_pkg.sv
package fpri_pkg;

   typedef enum logic [2:0] {
      DIR_NEAR_EVEN = 3'd0,
      DIR_NEAR_AWAY = 3'd1,
      DIR_UP        = 3'd2,
      DIR_DOWN      = 3'd3,
      DIR_ZERO      = 3'd4
   } dir_t;

   localparam logic [2:0] OP_NEAR_EVEN = 3'd0;
   localparam logic [2:0] OP_NEAR_AWAY = 3'd1;
   localparam logic [2:0] OP_UP        = 3'd2;
   localparam logic [2:0] OP_DOWN      = 3'd3;
   localparam logic [2:0] OP_ZERO      = 3'd4;
   localparam logic [2:0] OP_DYN       = 3'd5;
   localparam logic [2:0] OP_DYN_EXACT = 3'd6;

endpackage

// File: rtl/fpri_decode.sv
module fpri_decode
   import fpri_pkg::*;
(
   input  logic [2:0] op,
   input  logic [1:0] dyn_mode,
   output dir_t       dir,
   output logic       report_inexact
);

   dir_t dyn_dir;

   always_comb begin
      case (dyn_mode)
         2'b00:   dyn_dir = DIR_NEAR_EVEN;
         2'b01:   dyn_dir = DIR_UP;
         2'b10:   dyn_dir = DIR_DOWN;
         default: dyn_dir = DIR_ZERO;
      endcase
   end

   always_comb begin
      case (op)
         OP_NEAR_EVEN: dir = DIR_NEAR_EVEN;
         OP_NEAR_AWAY: dir = DIR_NEAR_AWAY;
         OP_UP:        dir = DIR_UP;
         OP_DOWN:      dir = DIR_DOWN;
         OP_ZERO:      dir = DIR_ZERO;
         default:      dir = dyn_dir;
      endcase
   end

   assign report_inexact = (op == OP_DYN_EXACT);

endmodule

// File: rtl/fpri_round.sv
module fpri_round
   import fpri_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  dir_t                 dir,
   input  logic                 report_inexact,
   output logic [EXP_W+MAN_W:0] res,
   output logic                 inexact,
   output logic                 invalid
);

   localparam int MAG_W = EXP_W + MAN_W;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EXP_BIAS = EXP_W'(BIAS);
   localparam logic [EXP_W-1:0] EXP_INTG = EXP_W'(BIAS + MAN_W);
   localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
   localparam logic [MAG_W-1:0] MAG_ONE  = {EXP_BIAS, {MAN_W{1'b0}}};
   localparam logic [MAG_W-1:0] MAG_LSB  = MAG_W'(1);

   logic             sgn;
   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] man;
   logic [MAG_W-1:0] mag;
   logic [EXP_W-1:0] nfrac;
   logic [MAG_W-1:0] mask, frac, half, unit;
   logic             odd, up, lost;

   assign sgn  = a[MAG_W];
   assign expo = a[MAG_W-1:MAN_W];
   assign man  = a[MAN_W-1:0];
   assign mag  = a[MAG_W-1:0];

   always_comb begin
      res     = a;
      invalid = 1'b0;
      lost    = 1'b0;
      up      = 1'b0;
      nfrac   = EXP_INTG - expo;
      unit    = MAG_LSB << nfrac;
      mask    = unit - MAG_LSB;
      half    = MAG_LSB << (nfrac - EXP_W'(1));
      frac    = mag & mask;
      odd     = |(mag & unit);
      if (&expo) begin
         if (man != '0) begin
            res[MAN_W-1] = 1'b1;
            invalid      = ~man[MAN_W-1];
         end
      end else if (expo >= EXP_INTG) begin
         res = a;
      end else if (expo < EXP_BIAS) begin
         if (mag != '0) begin
            lost = 1'b1;
            case (dir)
               DIR_NEAR_EVEN: up = (expo == EXP_HALF) && (man != '0);
               DIR_NEAR_AWAY: up = (expo == EXP_HALF);
               DIR_UP:        up = ~sgn;
               DIR_DOWN:      up = sgn;
               default:       up = 1'b0;
            endcase
            res = {sgn, up ? MAG_ONE : {MAG_W{1'b0}}};
         end
      end else begin
         lost = (frac != '0);
         case (dir)
            DIR_NEAR_EVEN: up = (frac > half) || ((frac == half) && odd);
            DIR_NEAR_AWAY: up = (frac >= half);
            DIR_UP:        up = ~sgn & lost;
            DIR_DOWN:      up = sgn & lost;
            default:       up = 1'b0;
         endcase
         res = {sgn, (mag & ~mask) + (up ? unit : {MAG_W{1'b0}})};
      end
   end

   assign inexact = lost & report_inexact;

endmodule

// File: rtl/fpri_delay.sv
module fpri_delay #(
   parameter int WIDTH = 34,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_v,
   input  logic [WIDTH-1:0] in_d,
   output logic             out_v,
   output logic [WIDTH-1:0] out_d
);

   logic [DEPTH-1:0] v;
   logic [WIDTH-1:0] d [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v[0] <= 1'b0;
               d[0] <= '0;
            end else begin
               v[0] <= in_v;
               if (in_v) d[0] <= in_d;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v[g] <= 1'b0;
               d[g] <= '0;
            end else begin
               v[g] <= v[g-1];
               if (v[g-1]) d[g] <= d[g-1];
            end
         end
      end
   end

   assign out_v = v[DEPTH-1];
   assign out_d = d[DEPTH-1];

endmodule

// File: rtl/fpri_top.sv
module fpri_top
   import fpri_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int LATENCY = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [2:0]           in_op,
   input  logic [1:0]           in_dyn_mode,
   input  logic [EXP_W+MAN_W:0] in_a,
   output logic                 out_valid,
   output logic [EXP_W+MAN_W:0] out_res,
   output logic                 out_inexact,
   output logic                 out_invalid
);

   localparam int W  = EXP_W + MAN_W + 1;
   localparam int PW = W + 2;

   if (LATENCY < 1) begin : g_bad_latency
      $error("fpri_top: LATENCY must be at least 1");
   end
   if (EXP_W < 3 || MAN_W < 2) begin : g_bad_format
      $error("fpri_top: format too narrow");
   end
   if ((1 << (EXP_W - 1)) - 1 + MAN_W >= (1 << EXP_W) - 1) begin : g_bad_range
      $error("fpri_top: mantissa too wide for exponent range");
   end

   dir_t         dir;
   logic         report_inexact;
   logic [W-1:0] r_res;
   logic         r_inexact, r_invalid;
   logic [PW-1:0] q_d;
   logic          q_v;

   fpri_decode u_decode (
      .op             (in_op),
      .dyn_mode       (in_dyn_mode),
      .dir            (dir),
      .report_inexact (report_inexact)
   );

   fpri_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
      .a              (in_a),
      .dir            (dir),
      .report_inexact (report_inexact),
      .res            (r_res),
      .inexact        (r_inexact),
      .invalid        (r_invalid)
   );

   fpri_delay #(.WIDTH(PW), .DEPTH(LATENCY)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (in_valid),
      .in_d  ({r_res, r_inexact, r_invalid}),
      .out_v (q_v),
      .out_d (q_d)
   );

   assign out_valid   = q_v;
   assign out_res     = q_d[PW-1:2];
   assign out_inexact = q_v & q_d[1];
   assign out_invalid = q_v & q_d[0];

endmodule

// File: rtl/fpri_checker.sv
module fpri_checker #(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int LATENCY = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [EXP_W+MAN_W:0] in_a,
   input logic                 out_valid,
   input logic [EXP_W+MAN_W:0] out_res,
   input logic                 out_inexact,
   input logic                 out_invalid
);

   localparam int MAG_W = EXP_W + MAN_W;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EXP_BIAS = EXP_W'(BIAS);
   localparam logic [EXP_W-1:0] EXP_INTG = EXP_W'(BIAS + MAN_W);

   logic [LATENCY-1:0] vq, sq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vq <= '0;
         sq <= '0;
      end else begin
         vq[0] <= in_valid;
         sq[0] <= in_a[MAG_W];
         for (int i = 1; i < LATENCY; i++) begin
            vq[i] <= vq[i-1];
            sq[i] <= sq[i-1];
         end
      end
   end

   logic [EXP_W-1:0] oexp;
   logic [MAN_W-1:0] oman;
   logic [MAN_W-1:0] omask;
   logic             integral;

   assign oexp = out_res[MAG_W-1:MAN_W];
   assign oman = out_res[MAN_W-1:0];

   always_comb begin
      omask    = '1;
      integral = 1'b1;
      if (&oexp) begin
         integral = 1'b1;
      end else if (oexp >= EXP_INTG) begin
         integral = 1'b1;
      end else if (oexp < EXP_BIAS) begin
         integral = (oexp == '0) && (oman == '0);
      end else begin
         omask    = MAN_W'({MAN_W{1'b1}} >> (oexp - EXP_BIAS));
         integral = ((oman & omask) == '0);
      end
   end

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vq[LATENCY-1]);

   assert_integral_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> integral);

   assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_inexact && out_invalid));

   assert_sign_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_res[MAG_W] == sq[LATENCY-1]));

   assert_quiet_nan_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> ((&oexp) && oman[MAN_W-1]));

   assert_idle_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_inexact && !out_invalid));

endmodule

bind fpri_top fpri_checker #(
   .EXP_W   (EXP_W),
   .MAN_W   (MAN_W),
   .LATENCY (LATENCY)
) u_fpri_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_a        (in_a),
   .out_valid   (out_valid),
   .out_res     (out_res),
   .out_inexact (out_inexact),
   .out_invalid (out_invalid)
);

// File: tb/tb_fpri_top.sv
module tb_fpri_top;

   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = 3'd0;
   logic [1:0]  in_dyn_mode = 2'd0;
   logic [31:0] in_a = 32'd0;
   logic        out_valid;
   logic [31:0] out_res;
   logic        out_inexact;
   logic        out_invalid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fpri_top #(.EXP_W(8), .MAN_W(23), .LATENCY(LAT)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_op       (in_op),
      .in_dyn_mode (in_dyn_mode),
      .in_a        (in_a),
      .out_valid   (out_valid),
      .out_res     (out_res),
      .out_inexact (out_inexact),
      .out_invalid (out_invalid)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_out(string tag, logic [31:0] eres, logic einx, logic einv);
      chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
      chk({tag, " result"}, out_res, eres);
      chk({tag, " inexact"}, {31'd0, out_inexact}, {31'd0, einx});
      chk({tag, " invalid"}, {31'd0, out_invalid}, {31'd0, einv});
   endtask

   task automatic run_one(string tag, logic [2:0] op, logic [1:0] md, logic [31:0] a,
                          logic [31:0] eres, logic einx, logic einv);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_dyn_mode = md; in_a = a;
      @(negedge clk);
      in_valid = 1'b0; in_a = 32'hDEAD_BEEF;
      repeat (LAT - 1) @(negedge clk);
      check_out(tag, eres, einx, einv);
   endtask

   task automatic test_reset();
      chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R13 reset flags", {30'd0, out_inexact, out_invalid}, 32'd0);
   endtask

   task automatic test_latency();
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'd4; in_a = 32'h40300000;
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 1; i < LAT; i++) begin
         chk("R1 early valid", {31'd0, out_valid}, 32'd0);
         @(negedge clk);
      end
      check_out("R1 on time", 32'h40000000, 1'b0, 1'b0);
      @(negedge clk);
      chk("R1 single pulse", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic test_stream();
      logic [31:0] ins [3] = '{32'h40200000, 32'hC0200000, 32'h3F333333};
      logic [31:0] exs [3] = '{32'h40400000, 32'hC0400000, 32'h3F800000};
      fork
         begin
            for (int k = 0; k < 3; k++) begin
               @(negedge clk);
               in_valid = 1'b1; in_op = 3'd1; in_a = ins[k];
            end
            @(negedge clk);
            in_valid = 1'b0;
         end
         begin
            @(negedge clk);
            repeat (LAT) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
               check_out("R1 R3 stream", exs[k], 1'b0, 1'b0);
               @(negedge clk);
            end
            chk("R1 stream end", {31'd0, out_valid}, 32'd0);
         end
      join
   endtask

   task automatic test_near_even();
      run_one("R2 2.5", 3'd0, 2'd0, 32'h40200000, 32'h40000000, 1'b0, 1'b0);
      run_one("R2 1.5", 3'd0, 2'd0, 32'h3FC00000, 32'h40000000, 1'b0, 1'b0);
      run_one("R2 -2.5", 3'd0, 2'd0, 32'hC0200000, 32'hC0000000, 1'b0, 1'b0);
      run_one("R2 2.75", 3'd0, 2'd0, 32'h40300000, 32'h40400000, 1'b0, 1'b0);
      run_one("R2 big tie", 3'd0, 2'd0, 32'h4A800001, 32'h4A800000, 1'b0, 1'b0);
   endtask

   task automatic test_near_away();
      run_one("R3 2.5", 3'd1, 2'd0, 32'h40200000, 32'h40400000, 1'b0, 1'b0);
      run_one("R3 -2.5", 3'd1, 2'd0, 32'hC0200000, 32'hC0400000, 1'b0, 1'b0);
      run_one("R3 1.25", 3'd1, 2'd0, 32'h3FA00000, 32'h3F800000, 1'b0, 1'b0);
   endtask

   task automatic test_directed();
      run_one("R4 up 1.25", 3'd2, 2'd0, 32'h3FA00000, 32'h40000000, 1'b0, 1'b0);
      run_one("R4 up -1.25", 3'd2, 2'd0, 32'hBFA00000, 32'hBF800000, 1'b0, 1'b0);
      run_one("R4 down 1.25", 3'd3, 2'd0, 32'h3FA00000, 32'h3F800000, 1'b0, 1'b0);
      run_one("R4 down -1.25", 3'd3, 2'd0, 32'hBFA00000, 32'hC0000000, 1'b0, 1'b0);
      run_one("R4 zero -2.75", 3'd4, 2'd0, 32'hC0300000, 32'hC0000000, 1'b0, 1'b0);
      run_one("R7 down exact", 3'd3, 2'd0, 32'h40400000, 32'h40400000, 1'b0, 1'b0);
   endtask

   task automatic test_dynamic();
      run_one("R5 mode00", 3'd5, 2'b00, 32'h40200000, 32'h40000000, 1'b0, 1'b0);
      run_one("R5 mode01", 3'd5, 2'b01, 32'h40200000, 32'h40400000, 1'b0, 1'b0);
      run_one("R5 mode10", 3'd5, 2'b10, 32'hC0200000, 32'hC0400000, 1'b0, 1'b0);
      run_one("R5 mode11", 3'd5, 2'b11, 32'hC0300000, 32'hC0000000, 1'b0, 1'b0);
      run_one("R5 op7 mode01", 3'd7, 2'b01, 32'h3FA00000, 32'h40000000, 1'b0, 1'b0);
   endtask

   task automatic test_exact_signal();
      run_one("R6 tie inexact", 3'd6, 2'b00, 32'h40200000, 32'h40000000, 1'b1, 1'b0);
      run_one("R6 exact 3.0", 3'd6, 2'b00, 32'h40400000, 32'h40400000, 1'b0, 1'b0);
      run_one("R6 small trunc", 3'd6, 2'b11, 32'h3F333333, 32'h00000000, 1'b1, 1'b0);
      run_one("R6 up 1.25", 3'd6, 2'b01, 32'h3FA00000, 32'h40000000, 1'b1, 1'b0);
   endtask

   task automatic test_passthrough();
      run_one("R8 large", 3'd6, 2'b01, 32'h4B000001, 32'h4B000001, 1'b0, 1'b0);
      run_one("R8 +inf", 3'd6, 2'b00, 32'h7F800000, 32'h7F800000, 1'b0, 1'b0);
      run_one("R8 -inf", 3'd2, 2'b00, 32'hFF800000, 32'hFF800000, 1'b0, 1'b0);
      run_one("R8 +0", 3'd2, 2'b00, 32'h00000000, 32'h00000000, 1'b0, 1'b0);
      run_one("R8 -0", 3'd6, 2'b10, 32'h80000000, 32'h80000000, 1'b0, 1'b0);
   endtask

   task automatic test_sign();
      run_one("R9 -0.3 up", 3'd2, 2'd0, 32'hBE99999A, 32'h80000000, 1'b0, 1'b0);
      run_one("R9 -0.5 even", 3'd0, 2'd0, 32'hBF000000, 32'h80000000, 1'b0, 1'b0);
   endtask

   task automatic test_nan();
      run_one("R10 snan", 3'd0, 2'd0, 32'h7F800001, 32'h7FC00001, 1'b0, 1'b1);
      run_one("R10 qnan", 3'd6, 2'd0, 32'hFFC00005, 32'hFFC00005, 1'b0, 1'b0);
   endtask

   task automatic test_small();
      run_one("R11 0.5 even", 3'd0, 2'd0, 32'h3F000000, 32'h00000000, 1'b0, 1'b0);
      run_one("R11 0.7 even", 3'd0, 2'd0, 32'h3F333333, 32'h3F800000, 1'b0, 1'b0);
      run_one("R11 0.5 away", 3'd1, 2'd0, 32'h3F000000, 32'h3F800000, 1'b0, 1'b0);
      run_one("R11 -0.5 away", 3'd1, 2'd0, 32'hBF000000, 32'hBF800000, 1'b0, 1'b0);
      run_one("R11 -0.3 down", 3'd3, 2'd0, 32'hBE99999A, 32'hBF800000, 1'b0, 1'b0);
      run_one("R11 0.7 down", 3'd3, 2'd0, 32'h3F333333, 32'h00000000, 1'b0, 1'b0);
      run_one("R11 0.7 zero", 3'd4, 2'd0, 32'h3F333333, 32'h00000000, 1'b0, 1'b0);
   endtask

   task automatic test_carry();
      run_one("R12 carry", 3'd2, 2'd0, 32'h4AFFFFFF, 32'h4B000000, 1'b0, 1'b0);
   endtask

   task automatic test_idle_flags();
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'd0; in_a = 32'h7F800001;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LAT) @(negedge clk);
      chk("R13 idle after flag", {30'd0, out_inexact, out_invalid}, 32'd0);
      chk("R13 idle valid", {31'd0, out_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_latency();
      test_stream();
      test_near_even();
      test_near_away();
      test_directed();
      test_dynamic();
      test_exact_signal();
      test_passthrough();
      test_sign();
      test_nan();
      test_small();
      test_carry();
      test_idle_flags();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule